// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one NAND flash transaction for a single chip-select bank. The transaction is a short program of 4-bit opcodes rather than a fixed state machine. The host presents the following alongside a start strobe:

- an opcode list of eight slots;
- a pair of command bytes;
- a block number and a page index within the block;
- a column;
- a transfer length;
- a user byte;
- two mode bits: large or small page, and main or spare area.

A start that names this block's bank copies all of these values. The sequencer then walks the slots from first to last.

Each slot either drives a bus cycle on the flash pins or waits for the ready/busy line. A bus cycle is a command byte with CLE high, or an address byte with ALE high. Bytes read back from the flash are written into a page buffer that sits outside the block. The block supplies the buffer address, which is derived from the page index, the area and the column.

Page read, spare-area read, identification read and block erase all run on the same engine with different slot lists. A status pair reports success or a ready timeout.

Top module: `nand_seq`

## Requirements
- R1: Slot k of `op_list` is bits [4k+3:4k] and the slots execute from k=0 upward. Opcode 0 ends the list, and so does any code from 9 to 15. After slot 7 the list ends by itself.
- R2: Opcode 1 sends `cmd_pair[7:0]` and opcode 2 sends `cmd_pair[15:8]`. Each is a single byte with CLE high and ALE low.
- R3: Opcode 3 sends the column with ALE high: one byte in small-page mode, or two bytes in large-page mode (low byte first, then bits 11:8). Opcode 4 sends the row with ALE high, least significant byte first: two bytes in small-page mode, three bytes in large-page mode. The row is `(blk_addr << 6) | page_idx` in large-page mode and `(blk_addr << 5) | page_idx[4:0]` in small-page mode. Opcode 5 sends `user_byte` with ALE high.
- R4: Every command or address byte is latched by a WE# low pulse of at least 2 clocks. Every read byte uses a RE# low pulse of at least 2 clocks. WE# and RE# are never low together, and CLE and ALE are never high together.
- R5: Opcode 6 waits until R/B# is high. Opcode 7 waits the same way and then reads bytes. Opcode 8 reads bytes without waiting. A byte is captured as RE# rises.
- R6: A transfer length of 0 reads the whole page plus spare area: 2112 bytes in large-page mode, 528 bytes in small-page mode. Any other length reads exactly that many bytes.
- R7: Read byte i is written to buffer address `sel*1024 + spare_off + col_addr + i`, taken modulo 8192. `sel` is `page_idx[0]*4` in large-page mode and `page_idx[2:0]` in small-page mode. `spare_off` is 2048 (large page) or 512 (small page) when `spare_sel` is high, and 0 otherwise.
- R8: A start is taken only when `go` is high, `go_bank` equals the BANK_ID parameter (default 0) and the block is idle. Any other start changes nothing.
- R9: `busy` and an active-low CE# are asserted together from the cycle after an accepted start until the list ends. CE# stays low across every byte of the transaction.
- R10: When a list ends normally, `done_ok` goes high as `busy` falls. `done_ok` and `done_err` both stay as they are until the next accepted start clears them.
- R11: If R/B# is still low TIMEOUT clocks after a wait begins polling, the list is abandoned, `done_err` goes high and `done_ok` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe |
| go_bank | input | 3 | Bank number carried by the start |
| op_list | input | 32 | Eight 4-bit opcode slots |
| cmd_pair | input | 16 | Command byte 0 (low) and command byte 1 (high) |
| blk_addr | input | 16 | Block number |
| page_idx | input | 6 | Page within block |
| col_addr | input | 12 | Column |
| xfer_len | input | 12 | Read length, 0 = page plus spare |
| user_byte | input | 8 | Byte sent by the user-address opcode |
| large_page | input | 1 | 1 = 2048-byte pages, 0 = 512-byte pages |
| spare_sel | input | 1 | Access the spare area |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus driven value |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus sampled value |
| nand_rb_n | input | 1 | Ready (1) / busy (0) |
| buf_we | output | 1 | Page buffer write strobe |
| buf_addr | output | 13 | Page buffer byte address |
| buf_wdata | output | 8 | Page buffer write data |
| busy | output | 1 | Transaction in progress |
| done_ok | output | 1 | Last transaction completed |
| done_err | output | 1 | Last transaction timed out on ready |

## Verification
The engine is driven with five different slot lists:

- A large-page full read with a non-zero block and an odd page exercises the two-byte column, the three-byte row, the second command and the upper buffer.
- A small-page spare read with a short length and a non-zero column shows the one-byte column, the two-byte row and the spare offset.
- A small-page full read covers the 528-byte default length.
- An identification read separates the user-byte opcode from the address opcodes and checks that CE# stays low across five reads.
- An erase shows that the wait-only opcode moves no data.

A list of eight command opcodes, lists cut short by opcode 0 and by an undefined code, a start for another bank, a start during a busy transaction, and an R/B# line held low each isolate one way the list can end or a start can be refused.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    parameter int OPW         = 4;
    parameter int SLOTS       = 8;
    parameter int BLK_W       = 16;
    parameter int PIDX_W      = 6;
    parameter int COL_W       = 12;
    parameter int CNT_W       = 12;
    parameter int ROW_W       = 24;
    parameter int BUF_AW      = 13;
    parameter int UNIT_SHIFT  = 10;
    parameter int LP_MAIN     = 2048;
    parameter int LP_SPARE    = 64;
    parameter int SP_MAIN     = 512;
    parameter int SP_SPARE    = 16;
    parameter int LP_PG_SHIFT = 6;
    parameter int SP_PG_SHIFT = 5;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 4'd0,
        OP_CMD0  = 4'd1,
        OP_CMD1  = 4'd2,
        OP_COL   = 4'd3,
        OP_ROW   = 4'd4,
        OP_UBYTE = 4'd5,
        OP_WAIT  = 4'd6,
        OP_WREAD = 4'd7,
        OP_READ  = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        BK_CMD,
        BK_ADDR,
        BK_READ
    } bus_kind_e;

    typedef struct packed {
        logic [OPW*SLOTS-1:0] ins;
        logic [15:0]          cmds;
        logic [BLK_W-1:0]     blk;
        logic [PIDX_W-1:0]    pidx;
        logic [COL_W-1:0]     col;
        logic [CNT_W-1:0]     cnt;
        logic [7:0]           ubyte;
        logic                 lp;
        logic                 spare;
    } job_t;

    // Codes above the last defined opcode behave as end-of-list.
    function automatic op_e decode_op(input logic [OPW-1:0] code);
        if (code > 4'd8) return OP_NOP;
        return op_e'(code);
    endfunction

    function automatic logic [ROW_W-1:0] make_row(input logic [BLK_W-1:0] blk,
                                                  input logic [PIDX_W-1:0] pidx,
                                                  input logic lp);
        logic [ROW_W-1:0] b;
        b = ROW_W'(blk);
        if (lp) return (b << LP_PG_SHIFT) | ROW_W'(pidx);
        return (b << SP_PG_SHIFT) | ROW_W'(pidx[SP_PG_SHIFT-1:0]);
    endfunction

    function automatic logic [1:0] addr_len(input op_e op, input logic lp);
        case (op)
            OP_COL:  return lp ? 2'd2 : 2'd1;
            OP_ROW:  return lp ? 2'd3 : 2'd2;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/nand_seq_bus.sv
module nand_seq_bus
    import nand_seq_pkg::*;
#(
    parameter int PULSE = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  bus_kind_e kind_in,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_in,
    output logic      ack,
    output logic [7:0] rdata,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic      dq_oe,
    output logic [7:0] dq_out
);
    localparam int CW = $clog2(PULSE) + 1;

    typedef enum logic [1:0] {B_IDLE, B_LOW, B_HIGH} bst_e;

    bst_e          st;
    logic [CW-1:0] cnt;
    bus_kind_e     kind;
    logic [7:0]    byte_q;
    logic          last;

    assign last = (cnt == CW'(PULSE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= B_IDLE;
            cnt    <= '0;
            kind   <= BK_CMD;
            byte_q <= '0;
            rdata  <= '0;
        end else begin
            case (st)
                B_IDLE: begin
                    if (req) begin
                        st     <= B_LOW;
                        cnt    <= '0;
                        kind   <= kind_in;
                        byte_q <= wbyte;
                    end
                end
                B_LOW: begin
                    if (last) begin
                        st  <= B_HIGH;
                        cnt <= '0;
                        if (kind == BK_READ) rdata <= dq_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                B_HIGH: begin
                    if (last) st <= B_IDLE;
                    else      cnt <= cnt + 1'b1;
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        ack    = (st == B_HIGH) && last;
        we_n   = !((st == B_LOW) && (kind != BK_READ));
        re_n   = !((st == B_LOW) && (kind == BK_READ));
        cle    = (st != B_IDLE) && (kind == BK_CMD);
        ale    = (st != B_IDLE) && (kind == BK_ADDR);
        dq_oe  = (st != B_IDLE) && (kind != BK_READ);
        dq_out = dq_oe ? byte_q : 8'h00;
    end

endmodule

// File: rtl/nand_seq_rbwait.sv
module nand_seq_rbwait #(
    parameter int WB_DLY  = 4,
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rb_n,
    output logic ready_ok,
    output logic timed_out
);
    localparam int TW = $clog2(TIMEOUT + WB_DLY + 2) + 1;

    typedef enum logic [1:0] {RW_IDLE, RW_SETTLE, RW_POLL} rw_e;

    rw_e           st;
    logic [TW-1:0] cnt;
    logic          rb_s1, rb_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RW_IDLE;
            cnt       <= '0;
            rb_s1     <= 1'b1;
            rb_s2     <= 1'b1;
            ready_ok  <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            rb_s1     <= rb_n;
            rb_s2     <= rb_s1;
            ready_ok  <= 1'b0;
            timed_out <= 1'b0;
            case (st)
                RW_IDLE: begin
                    if (start) begin
                        st  <= RW_SETTLE;
                        cnt <= '0;
                    end
                end
                RW_SETTLE: begin
                    // give the flash time to pull busy low before polling
                    if (cnt == TW'(WB_DLY - 1)) begin
                        st  <= RW_POLL;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RW_POLL: begin
                    if (rb_s2) begin
                        ready_ok <= 1'b1;
                        st       <= RW_IDLE;
                    end else if (cnt == TW'(TIMEOUT - 1)) begin
                        timed_out <= 1'b1;
                        st        <= RW_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RW_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_seq_bufmap.sv
module nand_seq_bufmap
    import nand_seq_pkg::*;
(
    input  logic              lp,
    input  logic              spare,
    input  logic [PIDX_W-1:0] pidx,
    input  logic [COL_W-1:0]  col,
    input  logic [CNT_W-1:0]  len,
    input  logic [CNT_W-1:0]  idx,
    output logic [BUF_AW-1:0] addr,
    output logic [CNT_W-1:0]  total
);
    localparam int SEL_W = BUF_AW - UNIT_SHIFT;

    logic [SEL_W-1:0]  sel;
    logic [BUF_AW-1:0] area_off;

    always_comb begin
        sel      = lp ? SEL_W'({pidx[0], 2'b00}) : SEL_W'(pidx[2:0]);
        area_off = !spare ? '0 : (lp ? BUF_AW'(LP_MAIN) : BUF_AW'(SP_MAIN));
        addr     = {sel, {UNIT_SHIFT{1'b0}}} + area_off + BUF_AW'(col) + BUF_AW'(idx);
        if (len != '0)  total = len;
        else if (lp)    total = CNT_W'(LP_MAIN + LP_SPARE);
        else            total = CNT_W'(SP_MAIN + SP_SPARE);
    end

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int BANK_W  = 3,
    parameter int BANK_ID = 0,
    parameter int PULSE   = 2,
    parameter int WB_DLY  = 4,
    parameter int TIMEOUT = 4096
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [BANK_W-1:0]      go_bank,
    input  logic [OPW*SLOTS-1:0]   op_list,
    input  logic [15:0]            cmd_pair,
    input  logic [BLK_W-1:0]       blk_addr,
    input  logic [PIDX_W-1:0]      page_idx,
    input  logic [COL_W-1:0]       col_addr,
    input  logic [CNT_W-1:0]       xfer_len,
    input  logic [7:0]             user_byte,
    input  logic                   large_page,
    input  logic                   spare_sel,
    output logic                   nand_ce_n,
    output logic                   nand_cle,
    output logic                   nand_ale,
    output logic                   nand_we_n,
    output logic                   nand_re_n,
    output logic [7:0]             nand_dq_out,
    output logic                   nand_dq_oe,
    input  logic [7:0]             nand_dq_in,
    input  logic                   nand_rb_n,
    output logic                   buf_we,
    output logic [BUF_AW-1:0]      buf_addr,
    output logic [7:0]             buf_wdata,
    output logic                   busy,
    output logic                   done_ok,
    output logic                   done_err
);
    localparam int SLOT_W = $clog2(SLOTS);

    typedef enum logic [2:0] {S_IDLE, S_DECODE, S_BYTES, S_WAIT, S_READ} st_e;

    st_e               state;
    job_t              job;
    logic [SLOT_W:0]   slot;
    logic [CNT_W-1:0]  bidx;
    logic              stat_ok, stat_err;

    op_e               cur_op;
    logic [ROW_W-1:0]  row;
    logic [7:0]        tx_byte;
    logic [1:0]        nbytes;
    bus_kind_e         kind;
    logic              bus_req, bus_ack;
    logic [7:0]        bus_rdata;
    logic              rw_start, rw_ok, rw_to;
    logic [BUF_AW-1:0] map_addr;
    logic [CNT_W-1:0]  total;
    logic              go_hit;

    assign go_hit = go && (go_bank == BANK_W'(BANK_ID)) && (state == S_IDLE);

    always_comb begin
        if (slot[SLOT_W]) cur_op = OP_NOP;
        else              cur_op = decode_op(job.ins[slot[SLOT_W-1:0]*OPW +: OPW]);
    end

    assign row    = make_row(job.blk, job.pidx, job.lp);
    assign nbytes = addr_len(cur_op, job.lp);

    always_comb begin
        case (cur_op)
            OP_CMD0:  tx_byte = job.cmds[7:0];
            OP_CMD1:  tx_byte = job.cmds[15:8];
            OP_UBYTE: tx_byte = job.ubyte;
            OP_COL:   tx_byte = bidx[0] ? 8'(job.col >> 8) : job.col[7:0];
            OP_ROW:   tx_byte = row[bidx[1:0]*8 +: 8];
            default:  tx_byte = 8'h00;
        endcase
        if (state == S_READ)                              kind = BK_READ;
        else if (cur_op == OP_CMD0 || cur_op == OP_CMD1)  kind = BK_CMD;
        else                                              kind = BK_ADDR;
    end

    assign bus_req  = (state == S_BYTES) || (state == S_READ);
    assign rw_start = (state == S_DECODE) && (cur_op == OP_WAIT || cur_op == OP_WREAD);

    nand_seq_bus #(.PULSE(PULSE)) u_bus (
        .clk     (clk),
        .rst     (rst),
        .req     (bus_req),
        .kind_in (kind),
        .wbyte   (tx_byte),
        .dq_in   (nand_dq_in),
        .ack     (bus_ack),
        .rdata   (bus_rdata),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_oe   (nand_dq_oe),
        .dq_out  (nand_dq_out)
    );

    nand_seq_rbwait #(.WB_DLY(WB_DLY), .TIMEOUT(TIMEOUT)) u_rbwait (
        .clk       (clk),
        .rst       (rst),
        .start     (rw_start),
        .rb_n      (nand_rb_n),
        .ready_ok  (rw_ok),
        .timed_out (rw_to)
    );

    nand_seq_bufmap u_map (
        .lp    (job.lp),
        .spare (job.spare),
        .pidx  (job.pidx),
        .col   (job.col),
        .len   (job.cnt),
        .idx   (bidx),
        .addr  (map_addr),
        .total (total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            job       <= '0;
            slot      <= '0;
            bidx      <= '0;
            stat_ok   <= 1'b0;
            stat_err  <= 1'b0;
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_wdata <= '0;
        end else begin
            buf_we <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (go_hit) begin
                        job.ins   <= op_list;
                        job.cmds  <= cmd_pair;
                        job.blk   <= blk_addr;
                        job.pidx  <= page_idx;
                        job.col   <= col_addr;
                        job.cnt   <= xfer_len;
                        job.ubyte <= user_byte;
                        job.lp    <= large_page;
                        job.spare <= spare_sel;
                        slot      <= '0;
                        stat_ok   <= 1'b0;
                        stat_err  <= 1'b0;
                        state     <= S_DECODE;
                    end
                end
                S_DECODE: begin
                    bidx <= '0;
                    case (cur_op)
                        OP_CMD0, OP_CMD1, OP_COL, OP_ROW, OP_UBYTE: state <= S_BYTES;
                        OP_WAIT, OP_WREAD:                          state <= S_WAIT;
                        OP_READ:                                    state <= S_READ;
                        default: begin
                            stat_ok <= 1'b1;
                            state   <= S_IDLE;
                        end
                    endcase
                end
                S_BYTES: begin
                    if (bus_ack) begin
                        if (bidx == CNT_W'(nbytes) - 1'b1) begin
                            slot  <= slot + 1'b1;
                            state <= S_DECODE;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                end
                S_WAIT: begin
                    if (rw_ok) begin
                        if (cur_op == OP_WREAD) begin
                            state <= S_READ;
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= S_DECODE;
                        end
                    end else if (rw_to) begin
                        stat_err <= 1'b1;
                        state    <= S_IDLE;
                    end
                end
                S_READ: begin
                    if (bus_ack) begin
                        buf_we    <= 1'b1;
                        buf_addr  <= map_addr;
                        buf_wdata <= bus_rdata;
                        if (bidx == total - 1'b1) begin
                            slot  <= slot + 1'b1;
                            state <= S_DECODE;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign nand_ce_n = (state == S_IDLE);
    assign done_ok   = stat_ok;
    assign done_err  = stat_err;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic clk,
    input logic rst,
    input logic go,
    input logic busy,
    input logic done_ok,
    input logic done_err,
    input logic buf_we,
    input logic we_n,
    input logic re_n,
    input logic cle,
    input logic ale,
    input logic ce_n
);
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    a_r4_latch_excl: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    a_r4_we_width: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |=> !we_n);

    a_r4_re_width: assert property (@(posedge clk) disable iff (rst)
        $fell(re_n) |=> !re_n);

    a_r9_strobe_in_ce: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !ce_n);

    a_r8_start_from_go: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));

    a_r10_status_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_ok && done_err));

    a_r7_write_in_txn: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> busy);

    a_r11_err_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done_err) |-> !busy);
endmodule

bind nand_seq nand_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .busy     (busy),
    .done_ok  (done_ok),
    .done_err (done_err),
    .buf_we   (buf_we),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .ce_n     (nand_ce_n)
);

// File: tb/nand_seq_test.sv
module nand_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [2:0]  go_bank = '0;
    logic [31:0] op_list = '0;
    logic [15:0] cmd_pair = '0;
    logic [15:0] blk_addr = '0;
    logic [5:0]  page_idx = '0;
    logic [11:0] col_addr = '0;
    logic [11:0] xfer_len = '0;
    logic [7:0]  user_byte = '0;
    logic        large_page = 1'b0;
    logic        spare_sel = 1'b0;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb_n;
    logic        buf_we;
    logic [12:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        busy, done_ok, done_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nand_seq #(.TIMEOUT(64)) uut (
        .clk(clk), .rst(rst), .go(go), .go_bank(go_bank), .op_list(op_list),
        .cmd_pair(cmd_pair), .blk_addr(blk_addr), .page_idx(page_idx),
        .col_addr(col_addr), .xfer_len(xfer_len), .user_byte(user_byte),
        .large_page(large_page), .spare_sel(spare_sel),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .busy(busy), .done_ok(done_ok), .done_err(done_err)
    );

    // flash model and pin monitor
    logic [7:0] log_b [0:63];
    logic       log_c [0:63];
    logic       log_a [0:63];
    int  nlog = 0, rd_cnt = 0, nbuf = 0, buf_bad = 0, ce_bad = 0, ce_low = 0;
    int  we_run = 0, re_run = 0, min_we = 99, min_re = 99, busy_left = 0;
    logic [12:0] first_addr = '0, last_addr = '0;
    logic prev_we = 1'b1, prev_re = 1'b1, stuck = 1'b0;

    assign nand_dq_in = 8'(rd_cnt) ^ 8'h5A;
    assign nand_rb_n  = !stuck && (busy_left == 0);

    always @(negedge clk) begin
        if (busy_left > 0) busy_left = busy_left - 1;
        if (!prev_we && nand_we_n) begin
            if (nlog < 64) begin
                log_b[nlog] = nand_dq_out;
                log_c[nlog] = nand_cle;
                log_a[nlog] = nand_ale;
            end
            nlog = nlog + 1;
            if (nand_cle && (nand_dq_out == 8'h30 || nand_dq_out == 8'hD0)) busy_left = 20;
        end
        if (!prev_re && nand_re_n) rd_cnt = rd_cnt + 1;
        if (!nand_we_n) we_run = we_run + 1;
        else if (!prev_we) begin
            if (we_run < min_we) min_we = we_run;
            we_run = 0;
        end
        if (!nand_re_n) re_run = re_run + 1;
        else if (!prev_re) begin
            if (re_run < min_re) min_re = re_run;
            re_run = 0;
        end
        if (buf_we) begin
            if (nbuf == 0) first_addr = buf_addr;
            if (buf_addr != first_addr + 13'(nbuf) || buf_wdata != (8'(nbuf) ^ 8'h5A))
                buf_bad = buf_bad + 1;
            last_addr = buf_addr;
            nbuf = nbuf + 1;
        end
        if (busy && nand_ce_n) ce_bad = ce_bad + 1;
        if (!nand_ce_n) ce_low = ce_low + 1;
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic chk_log(input int i, input logic [7:0] b, input bit c, input bit a, input string req);
        chk(log_b[i] == b, req, int'(log_b[i]), int'(b));
        chk(log_c[i] == c && log_a[i] == a, req, int'({log_c[i], log_a[i]}), int'({c, a}));
    endtask

    task automatic clear_mon();
        nlog = 0; rd_cnt = 0; nbuf = 0; buf_bad = 0; ce_bad = 0; ce_low = 0;
    endtask

    task automatic start(input logic [31:0] ins, input logic [15:0] cmds,
                         input logic [15:0] blk, input logic [5:0] pidx,
                         input logic [11:0] col, input logic [11:0] len,
                         input logic [7:0] ub, input bit lp, input bit sp,
                         input logic [2:0] bank);
        @(negedge clk);
        op_list = ins; cmd_pair = cmds; blk_addr = blk; page_idx = pidx;
        col_addr = col; xfer_len = len; user_byte = ub; large_page = lp;
        spare_sel = sp; go_bank = bank; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, {req, " completion within limit"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        chk(nand_ce_n && nand_we_n && nand_re_n, "R9 reset pins", int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
        chk(!nand_cle && !nand_ale, "R4 reset latches", int'({nand_cle, nand_ale}), 0);
        chk(!busy && !done_ok && !done_err, "R10 reset status", int'({busy, done_ok, done_err}), 0);
    endtask

    task automatic t_lp_read();
        clear_mon();
        start(32'h0007_2431, 16'h3000, 16'd5, 6'd3, 12'd0, 12'd0, 8'h00, 1'b1, 1'b0, 3'd0);
        wait_idle("R5 lp read");
        chk(nlog == 7, "R3 lp read byte count", nlog, 7);
        chk_log(0, 8'h00, 1, 0, "R2 lp cmd0");
        chk_log(1, 8'h00, 0, 1, "R3 lp col lo");
        chk_log(2, 8'h00, 0, 1, "R3 lp col hi");
        chk_log(3, 8'h43, 0, 1, "R3 lp row0");
        chk_log(4, 8'h01, 0, 1, "R3 lp row1");
        chk_log(5, 8'h00, 0, 1, "R3 lp row2");
        chk_log(6, 8'h30, 1, 0, "R2 lp cmd1");
        chk(nbuf == 2112, "R6 lp whole page length", nbuf, 2112);
        chk(first_addr == 13'd4096, "R7 lp buffer select", int'(first_addr), 4096);
        chk(last_addr == 13'd6207, "R7 lp last address", int'(last_addr), 6207);
        chk(buf_bad == 0, "R5 read data and address order", buf_bad, 0);
        chk(done_ok && !done_err, "R10 lp read status", int'({done_ok, done_err}), 2);
        chk(ce_bad == 0, "R9 ce during lp read", ce_bad, 0);
    endtask

    task automatic t_sp_spare();
        clear_mon();
        start(32'h0000_7431, 16'h0050, 16'd2, 6'd5, 12'd3, 12'd16, 8'h00, 1'b0, 1'b1, 3'd0);
        wait_idle("R5 sp spare read");
        chk(nlog == 4, "R3 sp byte count", nlog, 4);
        chk_log(0, 8'h50, 1, 0, "R2 sp spare cmd");
        chk_log(1, 8'h03, 0, 1, "R3 sp col");
        chk_log(2, 8'h45, 0, 1, "R3 sp row0");
        chk_log(3, 8'h00, 0, 1, "R3 sp row1");
        chk(nbuf == 16, "R6 explicit length", nbuf, 16);
        chk(first_addr == 13'd5635, "R7 sp spare offset", int'(first_addr), 5635);
        chk(buf_bad == 0, "R7 sp address order", buf_bad, 0);
    endtask

    task automatic t_sp_full();
        clear_mon();
        start(32'h0000_7431, 16'h0000, 16'd1, 6'd6, 12'd0, 12'd0, 8'h00, 1'b0, 1'b0, 3'd0);
        wait_idle("R6 sp full read");
        chk(nbuf == 528, "R6 sp whole page length", nbuf, 528);
        chk(first_addr == 13'd6144, "R7 sp buffer select", int'(first_addr), 6144);
        chk(buf_bad == 0, "R7 sp full order", buf_bad, 0);
    endtask

    task automatic t_read_id();
        clear_mon();
        start(32'h0000_0751, 16'h0090, 16'd7, 6'd0, 12'd0, 12'd5, 8'h00, 1'b1, 1'b0, 3'd0);
        wait_idle("R5 read id");
        chk(nlog == 2, "R3 id byte count", nlog, 2);
        chk_log(0, 8'h90, 1, 0, "R2 id cmd");
        chk_log(1, 8'h00, 0, 1, "R3 id user byte");
        chk(rd_cnt == 5 && nbuf == 5, "R6 id reads", rd_cnt, 5);
        chk(ce_bad == 0 && ce_low > 25, "R9 ce held through id", ce_bad, 0);
    endtask

    task automatic t_erase();
        clear_mon();
        start(32'h0000_6241, 16'hD060, 16'h0012, 6'd0, 12'd0, 12'd0, 8'h00, 1'b1, 1'b0, 3'd0);
        wait_idle("R5 erase");
        chk(nlog == 5, "R1 erase byte count", nlog, 5);
        chk_log(0, 8'h60, 1, 0, "R2 erase cmd0");
        chk_log(1, 8'h80, 0, 1, "R3 erase row0");
        chk_log(2, 8'h04, 0, 1, "R3 erase row1");
        chk_log(4, 8'hD0, 1, 0, "R2 erase cmd1");
        chk(nbuf == 0 && rd_cnt == 0, "R5 wait moves no data", nbuf, 0);
        chk(done_ok, "R10 erase ok", int'(done_ok), 1);
        repeat (5) @(negedge clk);
        chk(done_ok && !busy, "R10 status held", int'({done_ok, busy}), 2);
    endtask

    task automatic t_list_ends();
        clear_mon();
        start(32'h0000_0201, 16'hAA55, 16'd0, 6'd0, 12'd0, 12'd0, 8'h00, 1'b0, 1'b0, 3'd0);
        chk(busy && !done_ok, "R10 status cleared by start", int'({busy, done_ok}), 2);
        wait_idle("R1 nop end");
        chk(nlog == 1 && log_b[0] == 8'h55, "R1 nop ends list", nlog, 1);
        clear_mon();
        start(32'h0000_02B1, 16'hAA55, 16'd0, 6'd0, 12'd0, 12'd0, 8'h00, 1'b0, 1'b0, 3'd0);
        wait_idle("R1 bad code end");
        chk(nlog == 1, "R1 undefined code ends list", nlog, 1);
        clear_mon();
        start(32'h1111_1111, 16'h00C3, 16'd0, 6'd0, 12'd0, 12'd0, 8'h00, 1'b0, 1'b0, 3'd0);
        wait_idle("R1 eight slots");
        chk(nlog == 8, "R1 eight slots then end", nlog, 8);
        chk(done_ok, "R10 full list ok", int'(done_ok), 1);
    endtask

    task automatic t_bank_and_busy();
        clear_mon();
        start(32'h0000_0001, 16'h0011, 16'd0, 6'd0, 12'd0, 12'd0, 8'h00, 1'b0, 1'b0, 3'd3);
        repeat (10) @(negedge clk);
        chk(!busy && nlog == 0 && ce_low == 0, "R8 other bank ignored", nlog, 0);
        chk(done_ok, "R8 status untouched", int'(done_ok), 1);
        clear_mon();
        start(32'h0000_6241, 16'hD060, 16'h0012, 6'd0, 12'd0, 12'd0, 8'h00, 1'b1, 1'b0, 3'd0);
        repeat (3) @(negedge clk);
        start(32'h0000_0001, 16'h0077, 16'd0, 6'd0, 12'd0, 12'd0, 8'h00, 1'b0, 1'b0, 3'd0);
        wait_idle("R8 busy start");
        chk(nlog == 5 && log_b[0] == 8'h60, "R8 start while busy ignored", nlog, 5);
        repeat (6) @(negedge clk);
        chk(nlog == 5 && !busy, "R8 no second run", nlog, 5);
    endtask

    task automatic t_timeout();
        clear_mon();
        stuck = 1'b1;
        start(32'h0000_6241, 16'hD060, 16'h0001, 6'd0, 12'd0, 12'd0, 8'h00, 1'b1, 1'b0, 3'd0);
        wait_idle("R11 timeout");
        chk(done_err && !done_ok, "R11 timeout status", int'({done_ok, done_err}), 1);
        chk(nlog == 5, "R11 bytes before wait", nlog, 5);
        stuck = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lp_read();
        t_sp_spare();
        t_sp_full();
        t_read_id();
        t_erase();
        t_list_ends();
        t_bank_and_busy();
        t_timeout();
        chk(min_we >= 2, "R4 WE pulse width", min_we, 2);
        chk(min_re >= 2, "R4 RE pulse width", min_re, 2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule